// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames. Bytes enter through a write port into a sixteen-entry transmit queue. A serializer takes the oldest byte and sends it on a single output line. The line rests at logic 1. Each frame has a low start bit, then the data bits starting from the least significant one, then an optional parity bit, then one or two high stop bits. Bit timing comes from an external oversampling strobe: each bit lasts a fixed number of strobe pulses.

Two enable flags are held in a small control register: a module enable and a transmit enable. Both are set out of reset, so bytes written right after reset go out at once with eight data bits, no parity and one stop bit. The flags are checked only between frames, so clearing either one never cuts a frame short. The configuration pins for word length, parity and stop bits are captured only while the module enable is clear. Software therefore clears the module enable, sets up the line format, and then enables the block again.

Top module: `uart_txq`

## Requirements
- R1: The queue holds 16 bytes. After 15 accepted writes with nothing sent, `fifo_full` is 0. After the 16th it is 1. Queued bytes leave in write order.
- R2: A frame is sent as a 0 start bit, then the data bits least significant first, then the parity bit if one is selected, then the stop bits at 1.
- R3: A new frame starts only while both the module enable and the transmit enable are 1. With either one at 0, queued bytes stay unsent and `txd` stays 1.
- R4: Out of reset both enables are 1 and the line format is 8 data bits, no parity and one stop bit. A byte written right after reset is sent without any control write.
- R5: If an enable is cleared during a frame, that frame is still sent in full. Only then does the line go idle.
- R6: The values on `cfg_wlen`, `cfg_par` and `cfg_two_stop` are captured only in cycles where the module enable is 0. Changing them while it is 1 has no effect on the frames sent.
- R7: `txd` is 1 whenever no frame is in progress, including while the block is disabled.
- R8: Each bit lasts exactly 16 `baud_tick` pulses (32 clocks when the tick is high every second clock). The start bit begins on the first tick after a byte is taken from the queue. `txd` changes only on edges where `baud_tick` was 1.
- R9: A write while `fifo_full` is 1 is dropped and sets `overflow`. `overflow` stays 1 until a cycle with `ovf_clr` at 1 and no dropped write. A drop wins over a clear in the same cycle.
- R10: `busy` is 1 from the cycle a byte is taken until its last stop bit ends. It is also 1 whenever the queue holds data and both enables are 1. It is 0 when idle with the queue empty, and when idle while disabled.
- R11: Bytes queued while the block is disabled are kept. They are sent, in order, once both enables are 1 again.
- R12: `cfg_par` selects the parity bit as follows. 0 means no parity bit. 1 means even parity. 2 means odd parity. 3 means a bit that is always 0. 4 means a bit that is always 1. Values 5 to 7 mean no parity bit.
- R13: A `cfg_wlen` value v gives 5+v data bits. `cfg_two_stop` at 1 gives two stop bits; at 0 it gives one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Strobe that loads both enable flags |
| ctl_mod_en | input | 1 | Module enable value loaded on `ctl_wr` |
| ctl_tx_en | input | 1 | Transmit enable value loaded on `ctl_wr` |
| cfg_wlen | input | 2 | Word length code: 5+value data bits |
| cfg_par | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds 16 bytes |
| ovf_clr | input | 1 | Clears the overflow flag |
| overflow | output | 1 | Sticky flag for a dropped write |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit |
| txd | output | 1 | Serial output, high when idle |
| busy | output | 1 | Transmitter has work in progress or pending |

## Verification
Two things can land in the same clock cycle: the serializer taking a byte from a full queue, and a new write arriving. The bench sets this up by filling the queue while the transmit enable is clear. It then sets the enable and presents a write on the very next cycle, which is the cycle the first byte is taken. The full flag in force during that cycle decides the outcome. So the write must be dropped with `overflow` set, even though `fifo_full` reads 0 right afterwards. The following sixteen frames must carry exactly the original bytes, with no seventeenth frame. A second collision, a clear and a dropped write in the same cycle, must leave `overflow` set.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

   typedef enum logic [2:0] {
      PAR_NONE   = 3'd0,
      PAR_EVEN   = 3'd1,
      PAR_ODD    = 3'd2,
      PAR_STICK0 = 3'd3,
      PAR_STICK1 = 3'd4
   } par_mode_e;

   typedef struct packed {
      logic [1:0] wlen;
      par_mode_e  par;
      logic       two_stop;
   } line_cfg_t;

   localparam line_cfg_t CFG_RESET = '{wlen: 2'd3, par: PAR_NONE, two_stop: 1'b0};

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_ARMED = 2'd1,
      SH_SEND  = 2'd2
   } sh_state_e;

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty,
   output logic              wr_drop
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("txq_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW:0]       wp, rp;
   logic              wr_ok;

   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign empty   = (wp == rp);
   assign wr_ok   = wr_en && !full;
   assign wr_drop = wr_en && full;
   assign rd_data = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_ok)          wp <= wp + 1'b1;
         if (rd_en && !empty) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp[AW-1:0]] <= wr_data;
   end

endmodule

// File: rtl/txq_ctl.sv
module txq_ctl
   import uart_txq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctl_wr,
   input  logic      ctl_mod_en,
   input  logic      ctl_tx_en,
   input  line_cfg_t cfg_in,
   input  logic      ovf_set,
   input  logic      ovf_clr,
   output logic      mod_en_q,
   output logic      tx_en_q,
   output line_cfg_t cfg_q,
   output logic      overflow
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_en_q <= 1'b1;
         tx_en_q  <= 1'b1;
      end else if (ctl_wr) begin
         mod_en_q <= ctl_mod_en;
         tx_en_q  <= ctl_tx_en;
      end
   end

   // line format follows the pins only while the module is switched off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q <= CFG_RESET;
      else if (!mod_en_q) cfg_q <= cfg_in;
   end

   // a drop in the same cycle as a clear keeps the flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overflow <= 1'b0;
      else if (ovf_set) overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;
   end

endmodule

// File: rtl/txq_serializer.sv
module txq_serializer
   import uart_txq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ok,
   input  logic [DATA_W-1:0] data,
   input  line_cfg_t         cfg,
   input  logic              baud_tick,
   output logic              pop,
   output logic              in_frame,
   output logic              txd
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (OVS < 1) begin : g_bad_ovs
      $error("txq_serializer: OVS must be at least 1");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("txq_serializer: DATA_W must hold an 8-bit word");
   end

   sh_state_e          st;
   logic [FRAME_W-1:0] sreg, frame_nx;
   logic [CNT_W-1:0]   left, nbits_nx;
   logic               bit_end;

   // frame image: bit 0 leaves first
   always_comb begin : b_frame
      logic [3:0]        nd;
      logic [DATA_W-1:0] dmask, dm;
      logic              pen, pb;
      nd    = 4'd5 + {2'b00, cfg.wlen};
      dmask = ~({DATA_W{1'b1}} << nd);
      dm    = data & dmask;
      pen   = 1'b1;
      pb    = 1'b0;
      case (cfg.par)
         PAR_EVEN:   pb = ^dm;
         PAR_ODD:    pb = ~^dm;
         PAR_STICK0: pb = 1'b0;
         PAR_STICK1: pb = 1'b1;
         default:    pen = 1'b0;
      endcase
      frame_nx = {{(FRAME_W-DATA_W-1){1'b1}}, dm | ~dmask, 1'b0};
      if (pen) begin
         frame_nx = (frame_nx & ~({{(FRAME_W-1){1'b0}}, 1'b1} << (nd + 4'd1)))
                  | ({{(FRAME_W-1){1'b0}}, pb} << (nd + 4'd1));
      end
      nbits_nx = CNT_W'(nd) + CNT_W'(2) + CNT_W'(pen) + CNT_W'(cfg.two_stop);
   end

   if (OVS == 1) begin : g_no_sub
      assign bit_end = baud_tick;
   end else begin : g_sub
      localparam int SUB_W = $clog2(OVS);
      logic [SUB_W-1:0] sub;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              sub <= '0;
         else if (st != SH_SEND)  sub <= '0;
         else if (baud_tick)      sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + 1'b1;
      end
      assign bit_end = baud_tick && (sub == SUB_W'(OVS - 1));
   end

   assign pop      = (st == SH_IDLE) && start_ok;
   assign in_frame = (st != SH_IDLE);
   assign txd      = (st == SH_SEND) ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SH_IDLE;
         sreg <= '1;
         left <= '0;
      end else begin
         unique case (st)
            SH_IDLE: if (pop) begin
               sreg <= frame_nx;
               left <= nbits_nx;
               st   <= SH_ARMED;
            end
            SH_ARMED: if (baud_tick) st <= SH_SEND;
            SH_SEND: if (bit_end) begin
               if (left == CNT_W'(1)) st <= SH_IDLE;
               sreg <= {1'b1, sreg[FRAME_W-1:1]};
               left <= left - 1'b1;
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart_txq.sv
module uart_txq
   import uart_txq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_mod_en,
   input  logic              ctl_tx_en,
   input  logic [1:0]        cfg_wlen,
   input  logic [2:0]        cfg_par,
   input  logic              cfg_two_stop,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              fifo_full,
   input  logic              ovf_clr,
   output logic              overflow,
   input  logic              baud_tick,
   output logic              txd,
   output logic              busy
);
   logic              pop, in_frame, empty, wr_drop;
   logic              mod_en_q, tx_en_q, run_ok;
   logic [DATA_W-1:0] head;
   line_cfg_t         cfg_pins, cfg_q;

   assign cfg_pins = '{wlen: cfg_wlen, par: par_mode_e'(cfg_par), two_stop: cfg_two_stop};
   assign run_ok   = mod_en_q && tx_en_q;
   assign busy     = in_frame || (!empty && run_ok);

   txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_valid),
      .wr_data (wr_data),
      .rd_en   (pop),
      .rd_data (head),
      .full    (fifo_full),
      .empty   (empty),
      .wr_drop (wr_drop)
   );

   txq_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_mod_en (ctl_mod_en),
      .ctl_tx_en  (ctl_tx_en),
      .cfg_in     (cfg_pins),
      .ovf_set    (wr_drop),
      .ovf_clr    (ovf_clr),
      .mod_en_q   (mod_en_q),
      .tx_en_q    (tx_en_q),
      .cfg_q      (cfg_q),
      .overflow   (overflow)
   );

   txq_serializer #(.DATA_W(DATA_W), .OVS(OVS)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_ok  (run_ok && !empty),
      .data      (head),
      .cfg       (cfg_q),
      .baud_tick (baud_tick),
      .pop       (pop),
      .in_frame  (in_frame),
      .txd       (txd)
   );

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pop,
   input logic       in_frame,
   input logic       txd,
   input logic       busy,
   input logic       wr_valid,
   input logic       fifo_full,
   input logic       overflow,
   input logic       ovf_clr,
   input logic       baud_tick,
   input logic       mod_en_q,
   input logic       tx_en_q,
   input logic [5:0] cfg_bits
);

   p_pop_needs_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (mod_en_q && tx_en_q));

   p_no_pop_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame |-> !pop);

   p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mod_en_q |=> $stable(cfg_bits));

   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |-> txd);

   p_txd_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));

   p_full_write_sets_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && fifo_full) |=> overflow);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !ovf_clr) |=> overflow);

   p_busy_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame |-> busy);

endmodule

bind uart_txq uart_txq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pop       (pop),
   .in_frame  (in_frame),
   .txd       (txd),
   .busy      (busy),
   .wr_valid  (wr_valid),
   .fifo_full (fifo_full),
   .overflow  (overflow),
   .ovf_clr   (ovf_clr),
   .baud_tick (baud_tick),
   .mod_en_q  (mod_en_q),
   .tx_en_q   (tx_en_q),
   .cfg_bits  (cfg_q)
);

// File: tb/uart_txq_test.sv
module uart_txq_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ctl_wr, ctl_mod_en, ctl_tx_en;
   logic [1:0] cfg_wlen;
   logic [2:0] cfg_par;
   logic       cfg_two_stop;
   logic       wr_valid;
   logic [7:0] wr_data;
   logic       fifo_full, ovf_clr, overflow, baud_tick, txd, busy;
   int         n_chk = 0, n_fail = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   uart_txq uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mod_en(ctl_mod_en),
      .ctl_tx_en(ctl_tx_en), .cfg_wlen(cfg_wlen), .cfg_par(cfg_par),
      .cfg_two_stop(cfg_two_stop), .wr_valid(wr_valid), .wr_data(wr_data),
      .fifo_full(fifo_full), .ovf_clr(ovf_clr), .overflow(overflow),
      .baud_tick(baud_tick), .txd(txd), .busy(busy)
   );

   // tick high every second clock: one bit = 32 clocks
   initial begin
      baud_tick = 1'b0;
      forever begin
         @(negedge clk);
         baud_tick = ~baud_tick;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] efrm(input logic [7:0] d, input int wl, input int par,
                                        input bit two, output int n);
      logic [11:0] r;
      logic        p;
      int          k;
      r = '1; r[0] = 1'b0; k = 1; p = 1'b0;
      for (int i = 0; i < 5 + wl; i++) begin
         r[k] = d[i]; p ^= d[i]; k++;
      end
      case (par)
         1: begin r[k] = p;    k++; end
         2: begin r[k] = ~p;   k++; end
         3: begin r[k] = 1'b0; k++; end
         4: begin r[k] = 1'b1; k++; end
         default: ;
      endcase
      n = k + (two ? 2 : 1);
      return r;
   endfunction

   task automatic ctl(input logic m, input logic t);
      ctl_mod_en = m; ctl_tx_en = t; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      wr_data = d; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic set_cfg(input int wl, input int par, input bit two);
      cfg_wlen = 2'(wl); cfg_par = 3'(par); cfg_two_stop = two;
      ctl(1'b0, 1'b1);
      @(negedge clk);
      ctl(1'b1, 1'b1);
   endtask

   // samples each bit in its middle; returns at the middle of the last stop bit
   task automatic capture(input logic [7:0] d, input int wl, input int par, input bit two,
                          input string tag, input bit dis);
      logic [11:0] e, g;
      int n, w;
      e = efrm(d, wl, par, two, n);
      g = '1; w = 0;
      while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
      if (w >= 3000) begin chk(1'b0, {tag, " no start bit"}, 32'(txd), 0); return; end
      repeat (16) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         g[i] = txd;
         if (i < n - 1) begin
            if (dis && i == 2) begin ctl(1'b1, 1'b0); repeat (31) @(negedge clk); end
            else repeat (32) @(negedge clk);
         end
      end
      chk(g == e, tag, 32'(g), 32'(e));
   endtask

   task automatic watch_high(input int cycles, input string tag);
      bit ok = 1'b1;
      repeat (cycles) begin @(negedge clk); if (txd !== 1'b1) ok = 1'b0; end
      chk(ok, tag, 0, 1);
   endtask

   task automatic wait_idle();
      int w = 0;
      while (busy && w < 6000) begin @(negedge clk); w++; end
   endtask

   task automatic t_reset();
      chk(txd === 1'b1, "R7 txd after reset", 32'(txd), 1);
      chk(busy === 1'b0, "R10 busy after reset", 32'(busy), 0);
      chk(fifo_full === 1'b0 && overflow === 1'b0, "R9 flags after reset",
          32'({fifo_full, overflow}), 0);
   endtask

   task automatic t_basic();
      int w, cnt;
      wr(8'hA5);
      capture(8'hA5, 3, 0, 1'b0, "R4 R2 8N1 frame right after reset", 1'b0);
      wait_idle();
      wr(8'h5B);
      w = 0;
      while (txd !== 1'b0 && w < 20) begin @(negedge clk); w++; end
      chk(w >= 2 && w <= 3, "R8 start on first tick after pop", 32'(w), 3);
      cnt = 0;
      while (txd === 1'b0 && cnt < 100) begin @(negedge clk); cnt++; end
      chk(cnt == 32, "R8 start bit length 16 ticks", 32'(cnt), 32);
      wait_idle();
   endtask

   task automatic t_formats();
      set_cfg(0, 1, 1'b0); wr(8'h13); capture(8'h13, 0, 1, 1'b0, "R13 R12 5 bits even", 1'b0);
      set_cfg(1, 2, 1'b1); wr(8'h2C); capture(8'h2C, 1, 2, 1'b1, "R13 R12 6 bits odd two stop", 1'b0);
      set_cfg(2, 3, 1'b0); wr(8'h55); capture(8'h55, 2, 3, 1'b0, "R12 7 bits parity forced 0", 1'b0);
      set_cfg(3, 4, 1'b1); wr(8'hC3); capture(8'hC3, 3, 4, 1'b1, "R12 R2 8 bits parity forced 1", 1'b0);
      set_cfg(3, 6, 1'b0); wr(8'h81); capture(8'h81, 3, 6, 1'b0, "R12 code 6 means no parity", 1'b0);
      set_cfg(3, 0, 1'b0);
      wait_idle();
   endtask

   task automatic t_cfg_ignored();
      cfg_wlen = 2'd0; cfg_par = 3'd2; cfg_two_stop = 1'b1;
      @(negedge clk);
      wr(8'h96);
      capture(8'h96, 3, 0, 1'b0, "R6 pins ignored while enabled", 1'b0);
      wait_idle();
      cfg_wlen = 2'd3; cfg_par = 3'd0; cfg_two_stop = 1'b0;
   endtask

   task automatic t_disable();
      wr(8'h5A);
      capture(8'h5A, 3, 0, 1'b0, "R5 frame completes after disable", 1'b1);
      wait_idle();
      wr(8'h77);
      watch_high(300, "R3 no start with transmit enable clear");
      chk(busy === 1'b0, "R10 busy low while disabled with data", 32'(busy), 0);
      ctl(1'b1, 1'b1);
      capture(8'h77, 3, 0, 1'b0, "R11 kept byte sent after enable", 1'b0);
      wait_idle();
      ctl(1'b0, 1'b1);
      wr(8'h66);
      watch_high(300, "R3 R7 no start with module enable clear");
      ctl(1'b1, 1'b1);
      capture(8'h66, 3, 0, 1'b0, "R11 byte sent after module enable", 1'b0);
      wait_idle();
   endtask

   task automatic t_busy();
      chk(busy === 1'b0, "R10 busy low when idle", 32'(busy), 0);
      wr(8'h3C);
      chk(busy === 1'b1, "R10 busy high once queued", 32'(busy), 1);
      capture(8'h3C, 3, 0, 1'b0, "R2 frame for busy test", 1'b0);
      repeat (8) @(negedge clk);
      chk(busy === 1'b1, "R10 busy high during last stop bit", 32'(busy), 1);
      repeat (16) @(negedge clk);
      chk(busy === 1'b0, "R10 busy low after last stop bit", 32'(busy), 0);
   endtask

   task automatic t_overflow();
      ctl(1'b1, 1'b0);
      for (int i = 0; i < 15; i++) wr(8'h30 + 8'(i));
      chk(fifo_full === 1'b0, "R1 not full after 15 bytes", 32'(fifo_full), 0);
      wr(8'h3F);
      chk(fifo_full === 1'b1, "R1 full after 16 bytes", 32'(fifo_full), 1);
      wr(8'hDD);
      chk(overflow === 1'b1, "R9 write while full sets overflow", 32'(overflow), 1);
      repeat (5) @(negedge clk);
      chk(overflow === 1'b1, "R9 overflow sticky", 32'(overflow), 1);
      ovf_clr = 1'b1; wr_valid = 1'b1; wr_data = 8'hDE;
      @(negedge clk);
      ovf_clr = 1'b0; wr_valid = 1'b0;
      chk(overflow === 1'b1, "R9 drop wins over clear", 32'(overflow), 1);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      chk(overflow === 1'b0, "R9 clear", 32'(overflow), 0);
      // enable, then write in the very cycle the first byte is taken
      ctl_mod_en = 1'b1; ctl_tx_en = 1'b1; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0; wr_valid = 1'b1; wr_data = 8'hEE;
      @(negedge clk);
      wr_valid = 1'b0;
      chk(overflow === 1'b1 && fifo_full === 1'b0, "R9 write dropped in pop cycle",
          32'({overflow, fifo_full}), 32'h2);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      for (int i = 0; i < 16; i++) capture(8'h30 + 8'(i), 3, 0, 1'b0, "R1 R11 queued order", 1'b0);
      watch_high(400, "R1 no frame for dropped bytes");
      chk(busy === 1'b0, "R10 busy low after queue drained", 32'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ctl_wr = 1'b0; ctl_mod_en = 1'b1; ctl_tx_en = 1'b1;
      cfg_wlen = 2'd3; cfg_par = 3'd0; cfg_two_stop = 1'b0;
      wr_valid = 1'b0; wr_data = 8'h00; ovf_clr = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_formats();
      t_cfg_ignored();
      t_disable();
      t_busy();
      t_overflow();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule